// File: doc/BRIEF.md
# Parallel Configuration Target Sequencer

This block sits on the receiving end of a byte-wide passive configuration link inside a programmable device. After power-up it runs a power-on hold in which it pulls the shared open-drain status line low. It then moves through three stages in a fixed order: reset, configuration and initialization. Two lines decide when reset is entered and left. One is the device's own active-low configure request. The other is the shared status line, which any party on the link may hold low. The status line is modelled as a drive-low enable output plus a sampled input. The surrounding logic or the board combines the two with a pull-up.

While configuration is running, a byte is taken from the 8-bit data bus on each rising edge of the external data clock. That clock, the data bus, the configure request and the status line are all brought into the system clock domain through synchroniser stages of equal depth, so each sampled byte lines up with the clock edge that marked it. Every accepted byte leaves the block as a one-cycle valid pulse with its data. When the expected number of bytes has arrived, the block enters initialization. It stays there for a set number of cycles and then raises a done flag.

Top module: `cfg_target_seq`

## Requirements
- R1: After `rst`, the block spends POR_CYCLES system cycles in a power-on hold. During the hold `nstatus_drive_lo_o` is 1, `stage_o` is 0 (reset) and `done_o` is 0. Any rising edge of `nconfig_i` during the hold is ignored.
- R2: In the reset stage the block drives the status line low. It leaves reset only on a rising edge of `nconfig_i` that occurs after the power-on hold has ended. At that point it releases the status line (`nstatus_drive_lo_o` = 0).
- R3: Once the status line is released, the block stays in the reset stage (`stage_o` = 0) as long as the sampled `nstatus_i` reads low. It enters configuration (`stage_o` = 1) only when `nstatus_i` reads high.
- R4: In the configuration stage, each rising edge of `dclk_i` captures `data_i`. The captured byte appears on `byte_data_o` with `byte_valid_o` high for exactly one system cycle.
- R5: A rising edge of `dclk_i` in any stage other than configuration produces no `byte_valid_o` pulse.
- R6: When the BYTE_COUNT-th byte is captured since the byte counter was last cleared, the block moves to initialization (`stage_o` = 2). Before that count is reached, it stays in configuration.
- R7: Initialization lasts INIT_CYCLES cycles. After that, `done_o` goes to 1 and stays at 1, with `stage_o` at 2.
- R8: A low level on `nconfig_i` in any stage after the power-on hold returns the block to reset. It clears the byte counter and drives the status line low. A later rising edge restarts the count from zero.
- R9: If `nstatus_i` is pulled low externally during configuration, initialization or done, the block drops back to the released-reset wait (`stage_o` = 0, `done_o` = 0, `nstatus_drive_lo_o` = 0) and clears the byte counter. It resumes configuration when the line reads high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| nconfig_i | input | 1 | Active-low configure request, asynchronous |
| nstatus_i | input | 1 | Sampled level of the shared open-drain status line |
| dclk_i | input | 1 | External data clock, asynchronous |
| data_i | input | 8 | Configuration data bus |
| nstatus_drive_lo_o | output | 1 | 1 = pull the status line low |
| stage_o | output | 2 | Stage: 0 reset, 1 configuration, 2 initialization |
| byte_valid_o | output | 1 | One-cycle pulse per captured byte |
| byte_data_o | output | 8 | Last captured byte |
| done_o | output | 1 | Initialization complete |

## Verification
Several properties are checked on every cycle by the assertions:
- the valid pulse never lasts two cycles;
- bytes are only produced while configuration is active;
- a low configure request or a low status line forces the matching stage change on the next cycle;
- the counter is empty after a configure request;
- done implies the full byte count.

Other behaviours can only be shown by the bench's scenarios:
- that a configure edge during the power-on hold is lost for good;
- that an interrupted load really restarts from zero, so the block reaches initialization only after a full count;
- that bytes presented in reset, in the status-held wait and after done are dropped;
- that the byte order through the synchronisers is preserved.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_POR,
        S_RESET,
        S_WAIT,
        S_CONFIG,
        S_INIT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        STG_RESET  = 2'd0,
        STG_CONFIG = 2'd1,
        STG_INIT   = 2'd2
    } stage_t;

    // Asynchronous inputs, carried through one common synchroniser
    typedef struct packed {
        logic              ncfg;
        logic              nstat;
        logic              dclk;
        logic [DATA_W-1:0] data;
    } line_bus_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } beat_t;

    function automatic stage_t stage_of(seq_state_t s);
        case (s)
            S_CONFIG:       return STG_CONFIG;
            S_INIT, S_DONE: return STG_INIT;
            default:        return STG_RESET;
        endcase
    endfunction

    function automatic logic holds_line_low(seq_state_t s);
        return (s == S_POR) || (s == S_RESET);
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_byte_capture.sv
module cfg_byte_capture
    import cfg_seq_pkg::*;
#(
    parameter int BYTE_COUNT = 16,
    localparam int CNT_W     = $clog2(BYTE_COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic              dclk_s,
    input  logic [DATA_W-1:0] data_s,
    output beat_t             beat_o,
    output logic              last_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_COUNT - 1);

    logic dclk_q;
    logic take;

    assign take   = en && dclk_s && !dclk_q;
    assign last_o = take && (cnt_o == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q       <= 1'b0;
            cnt_o        <= '0;
            beat_o.valid <= 1'b0;
            beat_o.data  <= '0;
        end else begin
            dclk_q       <= dclk_s;
            beat_o.valid <= take && !clr;
            if (take && !clr) begin
                beat_o.data <= data_s;
            end
            if (clr) begin
                cnt_o <= '0;
            end else if (take) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    // R4: synchronised clock edges are at least two cycles apart
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        beat_o.valid |=> !beat_o.valid);

    // R6: the counter never runs past the expected total
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CNT_W'(BYTE_COUNT));
endmodule

// File: rtl/cfg_stage_fsm.sv
module cfg_stage_fsm
    import cfg_seq_pkg::*;
#(
    parameter int POR_CYCLES  = 1000,
    parameter int INIT_CYCLES = 8,
    localparam int TMR_MAX    = (POR_CYCLES > INIT_CYCLES) ? POR_CYCLES : INIT_CYCLES,
    localparam int TMR_W      = $clog2(TMR_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nconfig_s,
    input  logic       nstatus_s,
    input  logic       last_byte,
    output seq_state_t state_o,
    output logic       drive_lo_o,
    output logic       cap_en_o,
    output logic       clr_cnt_o,
    output logic       done_o
);
    localparam logic [TMR_W-1:0] POR_LAST  = TMR_W'(POR_CYCLES - 1);
    localparam logic [TMR_W-1:0] INIT_LAST = TMR_W'(INIT_CYCLES - 1);

    seq_state_t       nxt;
    logic [TMR_W-1:0] tmr, tmr_nxt;
    logic             ncfg_q;
    logic             ncfg_rise;

    assign ncfg_rise = nconfig_s && !ncfg_q;

    always_comb begin
        nxt     = state_o;
        tmr_nxt = tmr;
        if (state_o == S_POR) begin
            if (tmr == POR_LAST) begin
                nxt     = S_RESET;
                tmr_nxt = '0;
            end else begin
                tmr_nxt = tmr + 1'b1;
            end
        end else if (!nconfig_s) begin
            nxt     = S_RESET;
            tmr_nxt = '0;
        end else begin
            case (state_o)
                S_RESET:  if (ncfg_rise) nxt = S_WAIT;
                S_WAIT:   if (nstatus_s) nxt = S_CONFIG;
                S_CONFIG: begin
                    if (!nstatus_s) begin
                        nxt = S_WAIT;
                    end else if (last_byte) begin
                        nxt     = S_INIT;
                        tmr_nxt = '0;
                    end
                end
                S_INIT: begin
                    if (!nstatus_s) begin
                        nxt = S_WAIT;
                    end else if (tmr == INIT_LAST) begin
                        nxt = S_DONE;
                    end else begin
                        tmr_nxt = tmr + 1'b1;
                    end
                end
                S_DONE:   if (!nstatus_s) nxt = S_WAIT;
                default:  nxt = S_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= S_POR;
            tmr     <= '0;
            ncfg_q  <= 1'b0;
        end else begin
            state_o <= nxt;
            tmr     <= tmr_nxt;
            ncfg_q  <= nconfig_s;
        end
    end

    assign drive_lo_o = holds_line_low(state_o);
    assign cap_en_o   = (state_o == S_CONFIG);
    assign clr_cnt_o  = (nxt == S_POR) || (nxt == S_RESET) || (nxt == S_WAIT);
    assign done_o     = (state_o == S_DONE);

    // R1: the power-on hold can only give way to the reset stage
    a_r1_por_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == S_POR) |-> (state_o == S_POR || state_o == S_RESET));

    // R3: configuration is entered only after the status line read high
    a_r3_config_entry: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_CONFIG && $past(state_o) == S_WAIT) |-> $past(nstatus_s));

    // R8: a low request after the hold forces reset on the next cycle
    a_r8_request_low: assert property (@(posedge clk) disable iff (rst)
        (!nconfig_s && state_o != S_POR) |=> (state_o == S_RESET));

    // R9: an external low on the status line pauses the load
    a_r9_status_low: assert property (@(posedge clk) disable iff (rst)
        (!nstatus_s && nconfig_s &&
         (state_o == S_CONFIG || state_o == S_INIT || state_o == S_DONE))
        |=> (state_o == S_WAIT));
endmodule

// File: rtl/cfg_target_seq.sv
module cfg_target_seq
    import cfg_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int POR_CYCLES  = 1000,
    parameter int BYTE_COUNT  = 16,
    parameter int INIT_CYCLES = 8,
    localparam int CNT_W      = $clog2(BYTE_COUNT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nconfig_i,
    input  logic              nstatus_i,
    input  logic              dclk_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              nstatus_drive_lo_o,
    output logic [1:0]        stage_o,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_data_o,
    output logic              done_o
);
    line_bus_t        raw, synced;
    seq_state_t       state;
    beat_t            beat;
    logic             last_byte, cap_en, clr_cnt;
    logic [CNT_W-1:0] byte_cnt;

    assign raw = '{ncfg: nconfig_i, nstat: nstatus_i, dclk: dclk_i, data: data_i};

    // Data travels with its clock so each sampled byte matches its edge
    cfg_sync #(.STAGES(SYNC_STAGES), .W($bits(line_bus_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    cfg_stage_fsm #(.POR_CYCLES(POR_CYCLES), .INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .nconfig_s  (synced.ncfg),
        .nstatus_s  (synced.nstat),
        .last_byte  (last_byte),
        .state_o    (state),
        .drive_lo_o (nstatus_drive_lo_o),
        .cap_en_o   (cap_en),
        .clr_cnt_o  (clr_cnt),
        .done_o     (done_o)
    );

    cfg_byte_capture #(.BYTE_COUNT(BYTE_COUNT)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .en     (cap_en),
        .clr    (clr_cnt),
        .dclk_s (synced.dclk),
        .data_s (synced.data),
        .beat_o (beat),
        .last_o (last_byte),
        .cnt_o  (byte_cnt)
    );

    assign stage_o      = stage_of(state);
    assign byte_valid_o = beat.valid;
    assign byte_data_o  = beat.data;

    // R5: a byte comes out only from a capture made in configuration
    a_r5_valid_in_config: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> ($past(state) == S_CONFIG));

    // R7: done is reached only with the full count collected
    a_r7_done_full: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (byte_cnt == CNT_W'(BYTE_COUNT)));

    // R8: after a low request the byte counter is empty
    a_r8_count_cleared: assert property (@(posedge clk) disable iff (rst)
        (!synced.ncfg && state != S_POR) |=> (byte_cnt == '0));
endmodule

// File: tb/sim_cfg_target_seq.sv
module sim_cfg_target_seq;
    localparam int POR  = 200;
    localparam int NB   = 16;
    localparam int INIT = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nconfig = 1'b0;
    logic       ext_hold = 1'b1;
    logic       dclk = 1'b0;
    logic [7:0] data = 8'h00;
    logic       drive_lo, byte_valid, done;
    logic [1:0] stage;
    logic [7:0] byte_data;
    logic       nstatus_line;

    int checks = 0;
    int fails  = 0;
    int valid_cnt = 0;
    logic [7:0] expq [$];
    logic [7:0] seed = 8'h00;

    always #2.5 clk = ~clk;

    // Open-drain line with pull-up: low if the block or the bench pulls it
    assign nstatus_line = !drive_lo && !ext_hold;

    cfg_target_seq #(
        .SYNC_STAGES(2), .POR_CYCLES(POR), .BYTE_COUNT(NB), .INIT_CYCLES(INIT)
    ) u0 (
        .clk(clk), .rst(rst), .nconfig_i(nconfig), .nstatus_i(nstatus_line),
        .dclk_i(dclk), .data_i(data), .nstatus_drive_lo_o(drive_lo),
        .stage_o(stage), .byte_valid_o(byte_valid), .byte_data_o(byte_data),
        .done_o(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one byte on the bus with a DCLK pulse; push it if it should be taken
    task automatic send_byte(input bit expect_it);
        seed = seed + 8'h37;
        @(negedge clk);
        data = seed;
        dclk = 1'b1;
        if (expect_it) expq.push_back(seed);
        cycles(4);
        dclk = 1'b0;
        cycles(4);
    endtask

    // Monitor: every valid pulse is popped against the scoreboard (R4, R5)
    always @(negedge clk) begin
        if (!rst && byte_valid) begin
            valid_cnt++;
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R5: unexpected byte actual %0d expected none", byte_data);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                if (byte_data != e) begin
                    fails++;
                    $display("FAIL R4: byte actual %0d expected %0d", byte_data, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cycles(5);
        rst = 1'b0;
        cycles(1);
        // R1 reset state
        check("R1 drive", drive_lo, 1);
        check("R1 stage", stage, 0);
        check("R1 done", done, 0);
        check("R1 valid", byte_valid, 0);

        // R1: rising request during the hold is lost
        cycles(50);
        nconfig = 1'b1;
        cycles(20);
        check("R1 hold drive", drive_lo, 1);
        cycles(POR + 20);
        check("R2 no edge after hold", drive_lo, 1);
        check("R2 stage", stage, 0);

        // R5: byte in reset dropped
        send_byte(0);
        check("R5 reset byte", valid_cnt, 0);

        // R2: edge after hold releases the line
        nconfig = 1'b0;
        cycles(10);
        nconfig = 1'b1;
        cycles(10);
        check("R2 released", drive_lo, 0);
        check("R3 held wait", stage, 0);
        send_byte(0);
        check("R5 wait byte", valid_cnt, 0);

        // R3: release the external hold
        ext_hold = 1'b0;
        cycles(10);
        check("R3 config", stage, 1);

        // R4: partial load
        for (int i = 0; i < 5; i++) send_byte(1);
        check("R4 count", valid_cnt, 5);

        // R8: request low mid-load
        nconfig = 1'b0;
        cycles(10);
        check("R8 stage", stage, 0);
        check("R8 drive", drive_lo, 1);
        nconfig = 1'b1;
        cycles(10);
        check("R8 restart", stage, 1);

        // R6: counter restarted from zero
        for (int i = 0; i < NB - 1; i++) send_byte(1);
        check("R6 before last", stage, 1);
        send_byte(1);
        check("R6 init", stage, 2);
        check("R7 not yet done", done, 0);
        cycles(INIT + 10);
        check("R7 done", done, 1);
        check("R7 stage", stage, 2);

        // R5: byte after done dropped
        send_byte(0);
        check("R5 done byte", valid_cnt, 5 + NB);
        check("R7 stays done", done, 1);

        // R9: external low on status line
        ext_hold = 1'b1;
        cycles(10);
        check("R9 stage", stage, 0);
        check("R9 done clr", done, 0);
        check("R9 released", drive_lo, 0);
        send_byte(0);
        check("R9 no byte", valid_cnt, 5 + NB);
        ext_hold = 1'b0;
        cycles(10);
        check("R9 resume", stage, 1);
        for (int i = 0; i < NB - 1; i++) send_byte(1);
        check("R9 count cleared", stage, 1);
        send_byte(1);
        check("R9 init", stage, 2);
        cycles(INIT + 10);
        check("R9 done", done, 1);
        check("R4 queue empty", expq.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule